// File: doc/BRIEF.md
# Sticky Per-Bit Read Data Checker

This block sits beside a memory test traffic source and checks every read word that comes back from memory. Whenever the read-valid strobe is high, it compares the returned word against the word the traffic source expected, bit by bit. It keeps one pass flag for each data bit. A flag drops to 0 on the first miscompare of its bit and stays there until software clears it. When the first miscompare after a clear occurs, the block also saves the expected word and the returned word from that read, so software can see exactly what went wrong.

Software reaches all of this through a 32-bit register port with combinational reads and single-cycle writes. The wide pass-flag vector, the saved expected word and the saved returned word each appear as a run of consecutive 32-bit registers spaced 4 bytes apart. A status register reports whether any bit has failed. A clear register resets the failure state between test runs. The default data width is 576 bits (72 data lines times a width ratio of 8), which gives 18 registers per vector.

Top module: `stickyBitChecker`

## Requirements
- R1: On a cycle with `rdValid` high, pass flag bit x becomes 0 when `rdData[x]` differs from `expData[x]`. Flags whose bits match keep their value.
- R2: A pass flag that is 0 stays 0 through later reads, including reads where that bit matches, until a clear.
- R3: When `rdValid` is low, neither the pass flags nor the saved words change, whatever is on `rdData` and `expData`.
- R4: A write of any nonzero value to byte address 0x004 (the clear register) sets every pass flag to 1 and zeroes both saved words, starting with the next cycle. A write of zero to that address has no effect.
- R5: When a clear write and a miscompare with `rdValid` high fall in the same cycle, the clear wins: afterwards all flags are 1 and the saved words are zero.
- R6: The first miscompare after reset or after a clear stores `expData` and `rdData` into the saved-expected and saved-actual vectors. Later miscompares leave both saved vectors unchanged until the next clear.
- R7: Register N of the pass-flag vector is at byte address 0x100+4*N, of the saved-expected vector at 0x200+4*N, and of the saved-actual vector at 0x300+4*N. Bit j of register N holds vector bit 32*N+j. There are ceil(DATA_WIDTH/32) registers per vector.
- R8: Reading byte address 0x000 returns the aggregate fail status in bit 0, which is 1 exactly when at least one pass flag is 0. Bits 31:1 read as 0.
- R9: When DATA_WIDTH is not a multiple of 32, the bits of the last register of each vector that lie above DATA_WIDTH read as 0.
- R10: Reads of any address that maps to no register return 0. This covers the clear register, misaligned addresses, register indices at or beyond ceil(DATA_WIDTH/32), and addresses outside all windows.
- R11: After reset every pass flag is 1, both saved vectors are zero and the status bit reads 0.
- R12: Writes to any address other than the clear register leave the flags and saved words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdValid | input | 1 | High when a returned read word is present |
| rdData | input | DATA_WIDTH | Word returned from memory |
| expData | input | DATA_WIDTH | Word the traffic source expects |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |

## Verification
A table of read words drives the checker with the following cases:
- matching words;
- single-bit miscompares at the lowest and the highest bit of the bus;
- a full 32-bit word flipped;
- a miscompare presented with `rdValid` low;
- clears between runs.

These cases separate four behaviours: the per-bit comparison, stickiness across later matching reads, the gating by the valid strobe, and first-miss capture as opposed to last-miss capture. Directed tests then cover the remaining cases:
- a clear in the same cycle as a miscompare;
- a zero write to the clear register;
- writes to read-only windows;
- unmapped and misaligned reads.

A second instance with a 40-bit bus shows that the unused upper bits of the last register read as zero.

// File: rtl/stickyChkPkg.sv
package stickyChkPkg;
  localparam int IDX_W = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_PASS,
    SEL_EXP,
    SEL_ACT
  } rdSelE;

  typedef struct packed {
    logic             clear;
    logic             sample;
    rdSelE            rdSel;
    logic [IDX_W-1:0] rdIdx;
  } ctrlStrbT;
endpackage

// File: rtl/stickyChkCtrl.sv
module stickyChkCtrl
  import stickyChkPkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NREGS      = 18,
  parameter int STATUS_ADR = 'h000,
  parameter int CLEAR_ADR  = 'h004,
  parameter int PASS_BASE  = 'h100,
  parameter int EXP_BASE   = 'h200,
  parameter int ACT_BASE   = 'h300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output ctrlStrbT          strb
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(4 * NREGS);

  function automatic logic inWindow(input logic [ADDR_W-1:0] a, input int base);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(base);
    return (a >= ADDR_W'(base)) && (off < WIN_BYTES) && (off[1:0] == 2'b00);
  endfunction

  function automatic logic [IDX_W-1:0] winIndex(input logic [ADDR_W-1:0] a, input int base);
    logic [ADDR_W-1:0] off;
    off = (a - ADDR_W'(base)) >> 2;
    return off[IDX_W-1:0];
  endfunction

  always_comb begin
    strb.clear  = regWrEn && (regAddr == ADDR_W'(CLEAR_ADR)) && (regWrData != 32'd0);
    strb.sample = rdValid;
    strb.rdSel  = SEL_NONE;
    strb.rdIdx  = '0;
    if (regAddr == ADDR_W'(STATUS_ADR)) begin
      strb.rdSel = SEL_STATUS;
    end else if (inWindow(regAddr, PASS_BASE)) begin
      strb.rdSel = SEL_PASS;
      strb.rdIdx = winIndex(regAddr, PASS_BASE);
    end else if (inWindow(regAddr, EXP_BASE)) begin
      strb.rdSel = SEL_EXP;
      strb.rdIdx = winIndex(regAddr, EXP_BASE);
    end else if (inWindow(regAddr, ACT_BASE)) begin
      strb.rdSel = SEL_ACT;
      strb.rdIdx = winIndex(regAddr, ACT_BASE);
    end
  end

  // R10: any selected window register is word aligned
  a_r10_aligned_select: assert property (@(posedge clk) disable iff (rst)
    (strb.rdSel != SEL_NONE) |-> (regAddr[1:0] == 2'b00));

  // R4: clear strobe only arises from a write cycle
  a_r4_clear_from_write: assert property (@(posedge clk) disable iff (rst)
    strb.clear |-> regWrEn);
endmodule

// File: rtl/stickyChkData.sv
module stickyChkData
  import stickyChkPkg::*;
#(
  parameter int DATA_WIDTH = 576
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrbT              strb,
  input  logic [DATA_WIDTH-1:0] rdData,
  input  logic [DATA_WIDTH-1:0] expData,
  output logic [31:0]           regRdData
);
  localparam int NREGS = (DATA_WIDTH + 31) / 32;
  localparam int PAD_W = NREGS * 32;

  logic [DATA_WIDTH-1:0] passFlags;
  logic [DATA_WIDTH-1:0] capExp;
  logic [DATA_WIDTH-1:0] capAct;
  logic [DATA_WIDTH-1:0] missBits;
  logic                  anyFail;
  logic                  firstMiss;

  assign missBits  = rdData ^ expData;
  assign anyFail   = ~&passFlags;
  assign firstMiss = strb.sample && (|missBits) && !anyFail;

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      passFlags <= '1;
      capExp    <= '0;
      capAct    <= '0;
    end else begin
      if (strb.sample) passFlags <= passFlags & ~missBits;
      if (firstMiss) begin
        capExp <= expData;
        capAct <= rdData;
      end
    end
  end

  logic [PAD_W-1:0] passPad, expPad, actPad;
  logic [31:0]      passWords [NREGS];
  logic [31:0]      expWords  [NREGS];
  logic [31:0]      actWords  [NREGS];

  generate
    if (PAD_W > DATA_WIDTH) begin : g_pad
      assign passPad = {{(PAD_W - DATA_WIDTH){1'b0}}, passFlags};
      assign expPad  = {{(PAD_W - DATA_WIDTH){1'b0}}, capExp};
      assign actPad  = {{(PAD_W - DATA_WIDTH){1'b0}}, capAct};
    end else begin : g_nopad
      assign passPad = passFlags;
      assign expPad  = capExp;
      assign actPad  = capAct;
    end
    for (genvar w = 0; w < NREGS; w++) begin : g_word
      assign passWords[w] = passPad[32*w +: 32];
      assign expWords[w]  = expPad[32*w +: 32];
      assign actWords[w]  = actPad[32*w +: 32];
    end
  endgenerate

  logic idxOk;
  assign idxOk = (int'(strb.rdIdx) < NREGS);

  always_comb begin
    regRdData = 32'd0;
    unique case (strb.rdSel)
      SEL_STATUS: regRdData = {31'd0, anyFail};
      SEL_PASS:   if (idxOk) regRdData = passWords[strb.rdIdx];
      SEL_EXP:    if (idxOk) regRdData = expWords[strb.rdIdx];
      SEL_ACT:    if (idxOk) regRdData = actWords[strb.rdIdx];
      default:    regRdData = 32'd0;
    endcase
  end

  // R2: no flag returns to 1 except through a clear
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !strb.clear |=> ((passFlags & ~$past(passFlags)) == '0));

  // R3: without a valid read the flags hold
  a_r3_gated: assert property (@(posedge clk) disable iff (rst)
    (!strb.sample && !strb.clear) |=> $stable(passFlags));

  // R5: a clear always wins over a same-cycle miscompare
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> ((&passFlags) && (capExp == '0) && (capAct == '0)));

  // R6: once failing, the saved words hold until a clear
  a_r6_capture_hold: assert property (@(posedge clk) disable iff (rst)
    (anyFail && !strb.clear) |=> ($stable(capExp) && $stable(capAct)));
endmodule

// File: rtl/stickyBitChecker.sv
module stickyBitChecker
  import stickyChkPkg::*;
#(
  parameter int DATA_WIDTH = 576,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rdValid,
  input  logic [DATA_WIDTH-1:0] rdData,
  input  logic [DATA_WIDTH-1:0] expData,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData
);
  localparam int NREGS = (DATA_WIDTH + 31) / 32;

  ctrlStrbT strb;

  stickyChkCtrl #(
    .ADDR_W (ADDR_W),
    .NREGS  (NREGS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rdValid   (rdValid),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strb      (strb)
  );

  stickyChkData #(
    .DATA_WIDTH (DATA_WIDTH)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .rdData    (rdData),
    .expData   (expData),
    .regRdData (regRdData)
  );
endmodule

// File: tb/tb_stickyBitChecker.sv
module tb_stickyBitChecker;
  localparam int DW     = 576;
  localparam int NR     = (DW + 31) / 32;
  localparam int DW2    = 40;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              rdValid = 1'b0;
  logic [DW-1:0]     rdData  = '0;
  logic [DW-1:0]     expData = '0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;

  logic              rdValid2 = 1'b0;
  logic [DW2-1:0]    rdData2  = '0;
  logic [DW2-1:0]    expData2 = '0;
  logic [ADDR_W-1:0] regAddr2 = '0;
  logic [31:0]       regRdData2;

  stickyBitChecker #(.DATA_WIDTH(DW), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .rdValid(rdValid), .rdData(rdData), .expData(expData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData));

  stickyBitChecker #(.DATA_WIDTH(DW2), .ADDR_W(ADDR_W)) dut2 (
    .clk(clk), .rst(rst), .rdValid(rdValid2), .rdData(rdData2), .expData(expData2),
    .regAddr(regAddr2), .regWrEn(1'b0), .regWrData(32'd0), .regRdData(regRdData2));

  int nChecks = 0;
  int nFails  = 0;

  // model state
  logic [DW-1:0] mPass = '1;
  logic [DW-1:0] mExp  = '0;
  logic [DW-1:0] mAct  = '0;

  typedef struct packed {
    logic       clearFirst;
    logic       valid;
    logic       flipAll;
    logic [4:0] word;
    logic [4:0] bitPos;
    logic       flip;
    logic [3:0] req;
  } vecT;

  localparam int NVEC = 8;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'd1},  // R1 matching word
    '{1'b0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b1, 4'd1},  // R1 lowest bit miss, R6 capture
    '{1'b0, 1'b1, 1'b0, 5'd17, 5'd31, 1'b1, 4'd6},  // R6 second miss no recapture
    '{1'b0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'd2},  // R2 match keeps flags low
    '{1'b0, 1'b0, 1'b0, 5'd5,  5'd7,  1'b1, 4'd3},  // R3 miss without valid
    '{1'b1, 1'b1, 1'b1, 5'd9,  5'd0,  1'b1, 4'd4},  // R4 clear then full word miss
    '{1'b0, 1'b1, 1'b0, 5'd3,  5'd15, 1'b1, 4'd2},  // R2 accumulates
    '{1'b1, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'd4}   // R4 clear then match
  };

  function automatic logic [DW-1:0] patt(input int i);
    logic [DW-1:0] v;
    for (int w = 0; w < NR; w++) v[32*w +: 32] = 32'hA5C30000 ^ (32'(i) << 8) ^ 32'(w);
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic modelClear();
    mPass = '1; mExp = '0; mAct = '0;
  endtask

  task automatic modelSample(input logic [DW-1:0] a, input logic [DW-1:0] e);
    if ((a ^ e) != '0 && (&mPass)) begin
      mExp = e; mAct = a;
    end
    mPass = mPass & ~(a ^ e);
  endtask

  task automatic drive(input logic v, input logic [DW-1:0] a, input logic [DW-1:0] e);
    @(negedge clk);
    rdValid = v; rdData = a; expData = e;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  // R7 layout and R8 status checked against the model
  task automatic checkAll(input string tag);
    logic [31:0] d;
    readReg(12'h000, d);
    check({tag, " R8 status"}, d, {31'd0, ~&mPass});
    for (int n = 0; n < NR; n++) begin
      readReg(ADDR_W'(12'h100 + 4*n), d);
      check($sformatf("%s R7 pass[%0d]", tag, n), d, mPass[32*n +: 32]);
      readReg(ADDR_W'(12'h200 + 4*n), d);
      check($sformatf("%s R7 exp[%0d]", tag, n), d, mExp[32*n +: 32]);
      readReg(ADDR_W'(12'h300 + 4*n), d);
      check($sformatf("%s R7 act[%0d]", tag, n), d, mAct[32*n +: 32]);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0]   d;
    logic [DW-1:0] a, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    checkAll("R11 reset");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vecT v;
      v = VECS[i];
      if (v.clearFirst) begin
        writeReg(12'h004, 32'h1);
        modelClear();
      end
      e = patt(i);
      a = e;
      if (v.flip) begin
        if (v.flipAll) a[32*v.word +: 32] = ~a[32*v.word +: 32];
        else a[32*v.word + v.bitPos] = ~a[32*v.word + v.bitPos];
      end
      drive(v.valid, a, e);
      if (v.valid) modelSample(a, e);
      checkAll($sformatf("R%0d vec%0d", v.req, i));
    end

    // R4 zero write does not clear (state has failures from vec6 path? ensure one)
    e = patt(20); a = e; a[100] = ~a[100];
    drive(1'b1, a, e); modelSample(a, e);
    writeReg(12'h004, 32'h0);
    readReg(12'h000, d); check("R4 zero write keeps status", d, 32'h1);
    readReg(12'h10C, d); check("R4 zero write keeps flags", d, mPass[96 +: 32]);

    // R12 writes elsewhere ignored
    writeReg(12'h10C, 32'hFFFF_FFFF);
    writeReg(12'h000, 32'h0);
    writeReg(12'h20C, 32'h1234_5678);
    readReg(12'h10C, d); check("R12 pass word unchanged", d, mPass[96 +: 32]);
    readReg(12'h000, d); check("R12 status unchanged", d, 32'h1);
    readReg(12'h20C, d); check("R12 exp word unchanged", d, mExp[96 +: 32]);

    // R5 clear and miscompare in the same cycle
    e = patt(30); a = ~e;
    @(negedge clk);
    rdValid = 1'b1; rdData = a; expData = e;
    regAddr = 12'h004; regWrData = 32'h8000_0000; regWrEn = 1'b1;
    @(negedge clk);
    rdValid = 1'b0; regWrEn = 1'b0; regWrData = '0;
    modelClear();
    checkAll("R5 clear wins");

    // R10 unmapped reads
    readReg(12'h004, d); check("R10 clear reg reads 0", d, 32'h0);
    readReg(ADDR_W'(12'h100 + 4*NR), d); check("R10 pass index past end", d, 32'h0);
    readReg(12'h102, d); check("R10 misaligned", d, 32'h0);
    readReg(12'h400, d); check("R10 outside windows", d, 32'h0);
    readReg(12'hFFC, d); check("R10 top address", d, 32'h0);
    readReg(ADDR_W'(12'h300 + 4*NR), d); check("R10 act index past end", d, 32'h0);

    // R9 narrow instance: unused upper bits of last register read 0
    @(negedge clk); regAddr2 = 12'h104; #1;
    check("R9 narrow pass upper bits", regRdData2, 32'h0000_00FF);
    @(negedge clk);
    rdValid2 = 1'b1; expData2 = '1; rdData2 = 40'hFF_0000_0000;
    @(negedge clk);
    rdValid2 = 1'b0;
    regAddr2 = 12'h204; #1;
    check("R9 narrow exp upper bits", regRdData2, 32'h0000_00FF);
    @(negedge clk); regAddr2 = 12'h100; #1;
    check("R9 narrow pass low word", regRdData2, 32'h0000_0000);
    @(negedge clk); regAddr2 = 12'h108; #1;
    check("R9 narrow index past end", regRdData2, 32'h0);

    finishRun();
  end
endmodule